// File: doc/BRIEF.md
# Wait-State Bus Cycle Master

This block is the master end of a narrow parallel bus. It runs one read or one write at a time, to memory or to I/O space. A user request carries an address, write data, a direction bit and a space-select bit. The block accepts the request only while it is idle. It then walks the bus through a fixed sequence of clock phases: an address phase, a strobe phase, optional wait phases, a data phase and a closing phase. The request ends with a one-clock done pulse. Read data is returned on a held output.

The control scheme is a mix of strobe and handshake. A slave that keeps the ready line high sees the shortest, strobe-speed cycle. A slave that needs more time pulls ready low before the strobe phase ends, and the master then adds wait phases one at a time. The number of wait phases has a hard limit. If ready is still low when the limit is reached, the master closes the cycle anyway and reports a timeout together with done.

The memory space uses a 20-bit address and the I/O space a 16-bit address. Data is 8 bits wide. Each of the four access kinds has its own active-low strobe. The bidirectional data wires are split into an output, an output-enable and an input, so that a pad ring can join them.

Top module: `wsbus_master`

## Requirements
- R1: While reset is held and on the first cycle after it, every strobe is high and ale, done, timeout, busy and bus_doe are low.
- R2: The first cycle of a bus cycle is the address phase. In it, ale is high for exactly one clock, bus_addr carries the request address, and all strobes are high.
- R3: If chan_rdy is high at the clock edge that ends the strobe phase, no wait phase is added. done is then high in the 4th cycle after the accepting edge.
- R4: Each clock edge that samples chan_rdy low (at the end of the strobe phase or of a wait phase) adds one wait phase. With n such edges, n ≤ MAX_WAIT, done is high in cycle 4+n after acceptance.
- R5: At most MAX_WAIT (default 6) wait phases are added. If chan_rdy is still low at the end of the last one, the cycle completes and timeout is high in the same cycle as done. Otherwise timeout stays low.
- R6: In memory cycles bus_addr carries all 20 request bits. In I/O cycles bits 19:16 of bus_addr are 0 and bits 15:0 carry the request.
- R7: Exactly one strobe is used per access kind: mem_rd_n for a memory read, mem_wr_n for a memory write, io_rd_n for an I/O read and io_wr_n for an I/O write. The other three stay high.
- R8: The selected strobe is low from the strobe phase through the data phase, which is 2+w cycles for w wait phases. It is high in the closing phase.
- R9: For a read, rd_data takes bus_din at the edge that ends the data phase. It is valid with done and holds its value afterwards.
- R10: For a write, bus_doe is high and bus_dout equals the request data from the strobe phase through the closing phase (3+w cycles). For a read, bus_doe stays low.
- R11: A request raised while the block is busy is ignored: no further ale pulse, and the block goes idle the cycle after done.
- R12: done is high for exactly one clock per bus cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Start request (taken only when idle) |
| req_write | input | 1 | 1 = write, 0 = read |
| req_io | input | 1 | 1 = I/O space, 0 = memory space |
| req_addr | input | 20 | Request address |
| req_wdata | input | 8 | Write data |
| rd_data | output | 8 | Captured read data |
| done | output | 1 | One-clock completion pulse |
| timeout | output | 1 | Ready never returned; valid with done |
| busy | output | 1 | A bus cycle is in progress |
| bus_addr | output | 20 | Bus address, zero when idle |
| bus_ale | output | 1 | Address latch enable |
| mem_rd_n | output | 1 | Memory read strobe, active low |
| mem_wr_n | output | 1 | Memory write strobe, active low |
| io_rd_n | output | 1 | I/O read strobe, active low |
| io_wr_n | output | 1 | I/O write strobe, active low |
| bus_dout | output | 8 | Data driven to the bus |
| bus_doe | output | 1 | Output enable for bus_dout |
| bus_din | input | 8 | Data from the bus |
| chan_rdy | input | 1 | Slave ready |

## Verification
Time is counted from the edge that accepts a request. ale is due in cycle 1, the strobe from cycle 2 to cycle 3+w, and done, timeout and valid rd_data in cycle 4+w, where w is the number of low ready samples capped at MAX_WAIT. The bench model slave holds ready low for a chosen number of sampling edges. The bench samples every output at the falling edge, numbers each cycle of the transaction, and compares each observed phase length and the done cycle with 4+min(n,6) computed from the stimulus. Every access kind is swept against every stall length from zero to two past the cap.

// File: rtl/wsbus_pkg.sv
package wsbus_pkg;
  typedef enum logic [2:0] {
    PH_IDLE = 3'd0,
    PH_ADDR = 3'd1,
    PH_STRB = 3'd2,
    PH_WAIT = 3'd3,
    PH_DATA = 3'd4,
    PH_END  = 3'd5
  } phase_t;

  typedef enum logic [1:0] {
    K_MEM_RD = 2'd0,
    K_MEM_WR = 2'd1,
    K_IO_RD  = 2'd2,
    K_IO_WR  = 2'd3
  } kind_t;
endpackage

// File: rtl/wsbus_phase_seq.sv
module wsbus_phase_seq
  import wsbus_pkg::*;
#(
  parameter int MAX_WAIT = 6
) (
  input  logic   clk,
  input  logic   rst_n,
  input  logic   start,
  input  logic   rdy,
  output phase_t phase,
  output logic   to_flag
);
  localparam int CW = $clog2(MAX_WAIT + 1);
  localparam logic [CW-1:0] WLIM = CW'(MAX_WAIT);

  phase_t        ph_q, ph_d;
  logic [CW-1:0] wcnt_q, wcnt_d;
  logic          to_q, to_d;

  always_comb begin
    ph_d   = ph_q;
    wcnt_d = wcnt_q;
    to_d   = to_q;
    unique case (ph_q)
      PH_IDLE: begin
        if (start) begin
          ph_d   = PH_ADDR;
          wcnt_d = '0;
          to_d   = 1'b0;
        end
      end
      PH_ADDR: ph_d = PH_STRB;
      PH_STRB: begin
        if (rdy) begin
          ph_d = PH_DATA;
        end else begin
          ph_d   = PH_WAIT;
          wcnt_d = CW'(1);
        end
      end
      PH_WAIT: begin
        if (rdy) begin
          ph_d = PH_DATA;
        end else if (wcnt_q >= WLIM) begin
          ph_d = PH_DATA;
          to_d = 1'b1;
        end else begin
          wcnt_d = wcnt_q + CW'(1);
        end
      end
      PH_DATA: ph_d = PH_END;
      PH_END:  ph_d = PH_IDLE;
      default: ph_d = PH_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph_q   <= PH_IDLE;
      wcnt_q <= '0;
      to_q   <= 1'b0;
    end else begin
      ph_q   <= ph_d;
      wcnt_q <= wcnt_d;
      to_q   <= to_d;
    end
  end

  assign phase   = ph_q;
  assign to_flag = to_q;
endmodule

// File: rtl/wsbus_req_hold.sv
module wsbus_req_hold
  import wsbus_pkg::*;
#(
  parameter int MEM_AW = 20,
  parameter int IO_AW  = 16,
  parameter int DW     = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  phase_t            phase,
  input  logic              req_write,
  input  logic              req_io,
  input  logic [MEM_AW-1:0] req_addr,
  input  logic [DW-1:0]     req_wdata,
  input  logic [DW-1:0]     bus_din,
  output kind_t             kind,
  output logic [MEM_AW-1:0] bus_addr,
  output logic [DW-1:0]     bus_dout,
  output logic              bus_doe,
  output logic [DW-1:0]     rd_data
);
  localparam logic [MEM_AW-1:0] IO_MASK = {{(MEM_AW-IO_AW){1'b0}}, {IO_AW{1'b1}}};

  logic [MEM_AW-1:0] addr_q, addr_d;
  logic [DW-1:0]     wdat_q, wdat_d;
  logic              wr_q, wr_d, io_q, io_d;
  logic [DW-1:0]     rdat_q, rdat_d;
  logic              cap_en;

  assign cap_en = (phase == PH_DATA) && !wr_q;

  always_comb begin
    addr_d = addr_q;
    wdat_d = wdat_q;
    wr_d   = wr_q;
    io_d   = io_q;
    if (start) begin
      addr_d = req_io ? (req_addr & IO_MASK) : req_addr;
      wdat_d = req_wdata;
      wr_d   = req_write;
      io_d   = req_io;
    end
    rdat_d = cap_en ? bus_din : rdat_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q <= '0;
      wdat_q <= '0;
      wr_q   <= 1'b0;
      io_q   <= 1'b0;
      rdat_q <= '0;
    end else begin
      addr_q <= addr_d;
      wdat_q <= wdat_d;
      wr_q   <= wr_d;
      io_q   <= io_d;
      rdat_q <= rdat_d;
    end
  end

  assign kind     = kind_t'({io_q, wr_q});
  assign bus_addr = (phase == PH_IDLE) ? '0 : addr_q;
  assign bus_doe  = wr_q && (phase inside {PH_STRB, PH_WAIT, PH_DATA, PH_END});
  assign bus_dout = bus_doe ? wdat_q : '0;
  assign rd_data  = rdat_q;
endmodule

// File: rtl/wsbus_strobe_dec.sv
module wsbus_strobe_dec
  import wsbus_pkg::*;
(
  input  phase_t     phase,
  input  kind_t      kind,
  output logic [3:0] strobe_n
);
  logic active;
  assign active = phase inside {PH_STRB, PH_WAIT, PH_DATA};

  for (genvar g = 0; g < 4; g++) begin : g_strb
    assign strobe_n[g] = !(active && (kind == kind_t'(g)));
  end
endmodule

// File: rtl/wsbus_master.sv
module wsbus_master
  import wsbus_pkg::*;
#(
  parameter int MEM_AW   = 20,
  parameter int IO_AW    = 16,
  parameter int DW       = 8,
  parameter int MAX_WAIT = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic              req_write,
  input  logic              req_io,
  input  logic [MEM_AW-1:0] req_addr,
  input  logic [DW-1:0]     req_wdata,
  output logic [DW-1:0]     rd_data,
  output logic              done,
  output logic              timeout,
  output logic              busy,
  output logic [MEM_AW-1:0] bus_addr,
  output logic              bus_ale,
  output logic              mem_rd_n,
  output logic              mem_wr_n,
  output logic              io_rd_n,
  output logic              io_wr_n,
  output logic [DW-1:0]     bus_dout,
  output logic              bus_doe,
  input  logic [DW-1:0]     bus_din,
  input  logic              chan_rdy
);
  phase_t     phase;
  kind_t      kind;
  logic       to_flag;
  logic       start;
  logic [3:0] strobe_n;

  assign start = req_valid && (phase == PH_IDLE);

  wsbus_phase_seq #(.MAX_WAIT(MAX_WAIT)) u_seq (
    .clk     (clk),
    .rst_n   (rst_n),
    .start   (start),
    .rdy     (chan_rdy),
    .phase   (phase),
    .to_flag (to_flag)
  );

  wsbus_req_hold #(.MEM_AW(MEM_AW), .IO_AW(IO_AW), .DW(DW)) u_hold (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (start),
    .phase     (phase),
    .req_write (req_write),
    .req_io    (req_io),
    .req_addr  (req_addr),
    .req_wdata (req_wdata),
    .bus_din   (bus_din),
    .kind      (kind),
    .bus_addr  (bus_addr),
    .bus_dout  (bus_dout),
    .bus_doe   (bus_doe),
    .rd_data   (rd_data)
  );

  wsbus_strobe_dec u_dec (
    .phase    (phase),
    .kind     (kind),
    .strobe_n (strobe_n)
  );

  assign mem_rd_n = strobe_n[K_MEM_RD];
  assign mem_wr_n = strobe_n[K_MEM_WR];
  assign io_rd_n  = strobe_n[K_IO_RD];
  assign io_wr_n  = strobe_n[K_IO_WR];
  assign bus_ale  = (phase == PH_ADDR);
  assign done     = (phase == PH_END);
  assign timeout  = done && to_flag;
  assign busy     = (phase != PH_IDLE);
endmodule

// File: rtl/wsbus_master_chk.sv
module wsbus_master_chk #(
  parameter int MAX_WAIT = 6
) (
  input logic clk,
  input logic rst_n,
  input logic bus_ale,
  input logic mem_rd_n,
  input logic mem_wr_n,
  input logic io_rd_n,
  input logic io_wr_n,
  input logic bus_doe,
  input logic done,
  input logic timeout
);
  logic [3:0] strb;
  logic       any_strb;
  logic [7:0] run_q;

  assign strb     = ~{mem_rd_n, mem_wr_n, io_rd_n, io_wr_n};
  assign any_strb = |strb;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) run_q <= '0;
    else if (any_strb) run_q <= run_q + 8'd1;
    else run_q <= '0;
  end

  p_ale_quiet_r2: assert property (@(posedge clk) disable iff (!rst_n)
    bus_ale |-> !any_strb);
  p_ale_single_r2: assert property (@(posedge clk) disable iff (!rst_n)
    bus_ale |=> !bus_ale);
  p_strobe_follows_ale_r8: assert property (@(posedge clk) disable iff (!rst_n)
    bus_ale |=> any_strb);
  p_one_strobe_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(strb));
  p_timeout_with_done_r5: assert property (@(posedge clk) disable iff (!rst_n)
    timeout |-> done);
  p_wait_bound_r5: assert property (@(posedge clk) disable iff (!rst_n)
    run_q <= 8'(MAX_WAIT + 2));
  p_done_pulse_r12: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  p_done_no_strobe_r8: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !any_strb);
  p_doe_window_r10: assert property (@(posedge clk) disable iff (!rst_n)
    bus_doe |-> (!mem_wr_n || !io_wr_n || done));
endmodule

bind wsbus_master wsbus_master_chk #(.MAX_WAIT(MAX_WAIT)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .bus_ale  (bus_ale),
  .mem_rd_n (mem_rd_n),
  .mem_wr_n (mem_wr_n),
  .io_rd_n  (io_rd_n),
  .io_wr_n  (io_wr_n),
  .bus_doe  (bus_doe),
  .done     (done),
  .timeout  (timeout)
);

// File: tb/wsbus_master_test.sv
`timescale 1ns/1ps
module wsbus_master_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0, req_write = 1'b0, req_io = 1'b0;
  logic [19:0] req_addr = '0;
  logic [7:0]  req_wdata = '0;
  logic [7:0]  rd_data, bus_dout, bus_din;
  logic        done, timeout, busy, bus_ale, bus_doe, chan_rdy;
  logic        mem_rd_n, mem_wr_n, io_rd_n, io_wr_n;
  logic [19:0] bus_addr;
  logic        ld = 1'b0;
  int          ld_val = 0;
  int          slave_cnt = 0;
  int          n_chk = 0, n_fail = 0;

  always #4 clk = ~clk;

  wsbus_master uut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
    .req_io(req_io), .req_addr(req_addr), .req_wdata(req_wdata),
    .rd_data(rd_data), .done(done), .timeout(timeout), .busy(busy),
    .bus_addr(bus_addr), .bus_ale(bus_ale), .mem_rd_n(mem_rd_n),
    .mem_wr_n(mem_wr_n), .io_rd_n(io_rd_n), .io_wr_n(io_wr_n),
    .bus_dout(bus_dout), .bus_doe(bus_doe), .bus_din(bus_din),
    .chan_rdy(chan_rdy)
  );

  // model slave: ready low for slave_cnt strobe-cycle edges
  assign chan_rdy = (slave_cnt == 0);
  assign bus_din  = bus_addr[7:0] ^ 8'h5A;
  always @(posedge clk) begin
    if (ld) slave_cnt <= ld_val;
    else if ((!mem_rd_n || !mem_wr_n || !io_rd_n || !io_wr_n) && slave_cnt > 0)
      slave_cnt <= slave_cnt - 1;
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic run(input bit wr, input bit io, input logic [19:0] a,
                     input logic [7:0] d, input int n, input bit poke);
    int w, ale_n, ok_strb, bad_strb, doe_ok, doe_n, k, done_k;
    logic [19:0] ea, ale_addr;
    bit to_seen;
    logic [7:0] rd_seen;
    w = (n > 6) ? 6 : n;
    ea = io ? (a & 20'h0FFFF) : a;
    ale_n = 0; ok_strb = 0; bad_strb = 0; doe_ok = 0; doe_n = 0; done_k = -1;
    ale_addr = '0; to_seen = 0; rd_seen = '0;
    @(negedge clk);
    req_valid = 1; req_write = wr; req_io = io; req_addr = a; req_wdata = d;
    ld = 1; ld_val = n;
    for (k = 1; k <= 20; k++) begin
      @(negedge clk);
      ld = 0;
      req_valid = 0;
      if (poke && k == 1) begin
        req_valid = 1; req_addr = ~a; req_write = ~wr;
      end
      if (bus_ale) begin ale_n++; ale_addr = bus_addr; end
      begin
        logic [3:0] s;
        s = ~{io_wr_n, io_rd_n, mem_wr_n, mem_rd_n};
        if (s[{io, wr}]) ok_strb++;
        if ((s & ~(4'b1 << {io, wr})) != 0) bad_strb++;
      end
      if (bus_doe) begin doe_n++; if (bus_dout == d) doe_ok++; end
      if (done) begin done_k = k; to_seen = timeout; rd_seen = rd_data; break; end
    end
    req_valid = 0;
    chk(done_k == 4 + w, "R3/R4 done cycle", done_k, 4 + w);
    chk(to_seen == (n > 6), "R5 timeout", to_seen, n > 6);
    chk(ale_n == 1, "R2/R11 ale pulses", ale_n, 1);
    chk(ale_addr == ea, "R6 address", ale_addr, ea);
    chk(ok_strb == 2 + w, "R8 strobe length", ok_strb, 2 + w);
    chk(bad_strb == 0, "R7 wrong strobe", bad_strb, 0);
    chk(doe_n == (wr ? 3 + w : 0) && doe_ok == doe_n, "R10 write drive", doe_n, wr ? 3 + w : 0);
    if (!wr) chk(rd_seen == (ea[7:0] ^ 8'h5A), "R9 read data", rd_seen, ea[7:0] ^ 8'h5A);
    @(negedge clk);
    chk(!done, "R12 done pulse", done, 0);
    chk(!busy && !bus_ale, "R11 idle after done", {busy, bus_ale}, 0);
    if (!wr) chk(rd_data == (ea[7:0] ^ 8'h5A), "R9 read hold", rd_data, ea[7:0] ^ 8'h5A);
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk + 1, n_fail);
    $finish;
  end

  initial begin : main
    repeat (3) @(negedge clk);
    chk(mem_rd_n && mem_wr_n && io_rd_n && io_wr_n, "R1 strobes in reset", 0, 0);
    chk(!bus_ale && !done && !timeout && !busy && !bus_doe, "R1 outputs in reset",
        {bus_ale, done, timeout, busy, bus_doe}, 0);
    rst_n = 1;
    @(negedge clk);
    chk(mem_rd_n && mem_wr_n && io_rd_n && io_wr_n && !busy && !bus_ale && !done,
        "R1 after reset", busy, 0);
    for (int kd = 0; kd < 4; kd++) begin
      for (int n = 0; n <= 8; n++) begin
        run(kd[0], kd[1], 20'hF0000 | 20'(n * 20'h1357 + kd * 20'h0A3),
            8'(8'h3C + n * 17 + kd), n, n == 3);
      end
    end
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule